// File: doc/BRIEF.md
# Leveled Prioritized Interrupt Controller

This block gathers up to 64 interrupt request lines and tells a processor which one should be served next. Sources 1 to 7 are fixed external lines, each tied to the level equal to its number. Sources 8 to 63 are internal lines. Each has a control register that gives it a level (1 to 7) and a priority (0 to 7) within that level. A 64-bit mask blocks single sources, and a read-only pending view shows which sources take part in arbitration.

The block drives a registered interrupt level: the highest level that has any pending source. The processor acknowledges one level and gets back a vector one clock later. The vector is 64 plus the number of the best pending source at that level. If nothing is pending at that level, a spurious vector comes back. Arbitration picks the level first. Inside a level, a fixed external line ranks between programmable priorities 4 and 3.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the level output is 0, both mask words read 0xFFFFFFFF (all sources masked), and every control register reads 0.
- R2: The control register of source s (8..63) is at word address s. Bits [6:4] hold the level and bits [2:0] hold the priority; other bits read 0. Addresses 0..7 read 0 and writes to them are ignored.
- R3: An internal source whose level field is 0 never becomes pending, even with its request line active.
- R4: Mask bit s blocks source s. Mask bits 0..31 are at address 64 and bits 32..63 at address 65; a 1 means masked. Addresses 66 and 67 show pending bits 0..31 and 32..63. A pending bit is an active, unmasked, eligible request. Writes to addresses 66 and 67 are ignored.
- R5: The level output is registered. It equals the highest level among the pending sources as they were at the previous rising clock edge.
- R6: When acknowledge is high at a rising edge, vec_valid is high after that edge. vec_out then holds 64 plus the number of the winning pending source at the acknowledged level.
- R7: Inside one level, a higher priority wins. Between equal level and priority, the lower source number wins.
- R8: External line n (ext_req bit n-1, n = 1..7) belongs to level n. It beats programmable sources of that level with priority 0..3 and loses to those with priority 4..7.
- R9: An acknowledge of level 0, or of a level with no pending source, returns the spurious vector 24.
- R10: A source at a higher level beats any source at a lower level, whatever their priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req | input | 7 | Fixed external request lines, bit n-1 = source n |
| int_req | input | 56 | Internal request lines, bit k = source k+8 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ack_valid | input | 1 | Acknowledge strobe from the processor |
| ack_level | input | 3 | Level being acknowledged |
| ipl_o | output | 3 | Highest pending level, registered |
| vec_valid | output | 1 | Vector valid, one clock after acknowledge |
| vec_out | output | 8 | Returned vector |

## Verification
The bench runs several request patterns. In one, two internal sources sit at different levels with inverted priorities; this shows that the level decides before the priority does. In another, three sources share one level and two of them have the same priority; this checks that priority decides first and the lower number breaks the tie. An external line is set against a programmable source of priority 3 and then of priority 4, which places it exactly at the middle of its level. Masked sources, sources at level 0, and acknowledges of empty levels each check that a blocked request reaches neither the level output nor the vector, and that the spurious vector comes back instead.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int LVL_W  = 3;
   localparam int PRI_W  = 3;
   localparam int RANK_W = 4;
   localparam logic [RANK_W-1:0] EXT_RANK = 4'd4;

   // programmable priority mapped to a rank that leaves slot 4 for the fixed line
   function automatic logic [RANK_W-1:0] prog_rank(input logic [PRI_W-1:0] p);
      logic [RANK_W-1:0] r;
      r = {1'b0, p};
      if (p >= 3'd4) r = r + 4'd1;
      return r;
   endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter int FIRST_PROG = 8,
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   input  logic [NUM_SRC-1:0]  pend,
   output logic [LVL_W-1:0]    ctl_lvl [NUM_SRC],
   output logic [PRI_W-1:0]    ctl_pri [NUM_SRC],
   output logic [NUM_SRC-1:0]  mask
);
   localparam logic [ADDR_W-1:0] MASK_LO = ADDR_W'(64);
   localparam logic [ADDR_W-1:0] MASK_HI = ADDR_W'(65);
   localparam logic [ADDR_W-1:0] PEND_LO = ADDR_W'(66);
   localparam logic [ADDR_W-1:0] PEND_HI = ADDR_W'(67);

   logic [63:0] mask_q;
   logic [63:0] pend64;

   assign pend64 = 64'(pend);
   assign mask   = mask_q[NUM_SRC-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (we) begin
         if (addr == MASK_LO) mask_q[31:0]  <= wdata[31:0];
         if (addr == MASK_HI) mask_q[63:32] <= wdata[31:0];
      end
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_ctl
      if (s < FIRST_PROG) begin : g_fixed
         assign ctl_lvl[s] = '0;
         assign ctl_pri[s] = '0;
      end else begin : g_prog
         logic [LVL_W-1:0] lvl_q;
         logic [PRI_W-1:0] pri_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q <= '0;
               pri_q <= '0;
            end else if (we && addr == ADDR_W'(s)) begin
               lvl_q <= wdata[6:4];
               pri_q <= wdata[2:0];
            end
         end
         assign ctl_lvl[s] = lvl_q;
         assign ctl_pri[s] = pri_q;
      end
   end

   always_comb begin
      rdata = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (addr == ADDR_W'(s)) begin
            rdata[6:4] = ctl_lvl[s];
            rdata[2:0] = ctl_pri[s];
         end
      end
      if (addr == MASK_LO) rdata[31:0] = mask_q[31:0];
      if (addr == MASK_HI) rdata[31:0] = mask_q[63:32];
      if (addr == PEND_LO) rdata[31:0] = pend64[31:0];
      if (addr == PEND_HI) rdata[31:0] = pend64[63:32];
   end

   // R4
   pend_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr == PEND_LO || addr == PEND_HI)) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_level_sel.sv
module irqc_level_sel
   import irqc_pkg::*;
#(
   parameter int NUM_SRC    = 64,
   parameter int FIRST_PROG = 8,
   localparam int NUM_EXT   = FIRST_PROG - 1,
   localparam int NUM_INT   = NUM_SRC - FIRST_PROG,
   localparam int IDX_W     = $clog2(NUM_SRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_EXT-1:0]  ext_req,
   input  logic [NUM_INT-1:0]  int_req,
   input  logic [LVL_W-1:0]    ctl_lvl [NUM_SRC],
   input  logic [PRI_W-1:0]    ctl_pri [NUM_SRC],
   input  logic [NUM_SRC-1:0]  mask,
   input  logic [LVL_W-1:0]    sel_level,
   output logic [NUM_SRC-1:0]  pend,
   output logic [LVL_W-1:0]    top_level,
   output logic                win_found,
   output logic [IDX_W-1:0]    win_idx
);
   logic [LVL_W-1:0]  src_lvl  [NUM_SRC];
   logic [RANK_W-1:0] src_rank [NUM_SRC];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s == 0) begin : g_none
         assign src_lvl[s]  = '0;
         assign src_rank[s] = '0;
         assign pend[s]     = 1'b0;
      end else if (s < FIRST_PROG) begin : g_ext
         assign src_lvl[s]  = LVL_W'(s);
         assign src_rank[s] = EXT_RANK;
         assign pend[s]     = ext_req[s-1] & ~mask[s];
      end else begin : g_int
         assign src_lvl[s]  = ctl_lvl[s];
         assign src_rank[s] = prog_rank(ctl_pri[s]);
         assign pend[s]     = int_req[s-FIRST_PROG] & ~mask[s] & (ctl_lvl[s] != '0);
      end
   end

   always_comb begin
      top_level = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (pend[s] && src_lvl[s] > top_level) top_level = src_lvl[s];
      end
   end

   always_comb begin
      logic [RANK_W-1:0] best;
      best      = '0;
      win_found = 1'b0;
      win_idx   = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         if (pend[s] && sel_level != '0 && src_lvl[s] == sel_level &&
             (!win_found || src_rank[s] > best)) begin
            win_found = 1'b1;
            best      = src_rank[s];
            win_idx   = IDX_W'(s);
         end
      end
   end

   // R6
   win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_found |-> (pend[win_idx] && src_lvl[win_idx] == sel_level));

   // R9
   no_win_lvl0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_level == '0) |-> !win_found);

   // R5
   top_covers_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_found |-> (top_level >= sel_level));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int          NUM_SRC    = 64,
   parameter int          FIRST_PROG = 8,
   parameter int          ADDR_W     = 7,
   parameter int          DATA_W     = 32,
   parameter int          VEC_W      = 8,
   parameter int          VEC_BASE   = 64,
   parameter int          SPUR_VEC   = 24,
   localparam int         NUM_EXT    = FIRST_PROG - 1,
   localparam int         NUM_INT    = NUM_SRC - FIRST_PROG,
   localparam int         IDX_W      = $clog2(NUM_SRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_EXT-1:0]  ext_req,
   input  logic [NUM_INT-1:0]  int_req,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic                ack_valid,
   input  logic [LVL_W-1:0]    ack_level,
   output logic [LVL_W-1:0]    ipl_o,
   output logic                vec_valid,
   output logic [VEC_W-1:0]    vec_out
);
   if (FIRST_PROG != 8) begin : g_bad_first
      $error("FIRST_PROG must be 8: one fixed line per level 1..7");
   end
   if (NUM_SRC > 64 || NUM_SRC <= FIRST_PROG) begin : g_bad_num
      $error("NUM_SRC must lie in FIRST_PROG+1..64");
   end
   if (DATA_W != 32 || ADDR_W < 7) begin : g_bad_bus
      $error("register bus needs 32-bit data and at least 7 address bits");
   end
   if (VEC_BASE + NUM_SRC > (1 << VEC_W) || SPUR_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("vector range does not fit VEC_W");
   end

   logic [LVL_W-1:0]   ctl_lvl [NUM_SRC];
   logic [PRI_W-1:0]   ctl_pri [NUM_SRC];
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] pend;
   logic [LVL_W-1:0]   top_level;
   logic               win_found;
   logic [IDX_W-1:0]   win_idx;

   irqc_regs #(
      .NUM_SRC(NUM_SRC), .FIRST_PROG(FIRST_PROG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .pend(pend), .ctl_lvl(ctl_lvl), .ctl_pri(ctl_pri), .mask(mask)
   );

   irqc_level_sel #(
      .NUM_SRC(NUM_SRC), .FIRST_PROG(FIRST_PROG)
   ) i_sel (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
      .ctl_lvl(ctl_lvl), .ctl_pri(ctl_pri), .mask(mask), .sel_level(ack_level),
      .pend(pend), .top_level(top_level), .win_found(win_found), .win_idx(win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ipl_o     <= '0;
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         ipl_o     <= top_level;
         vec_valid <= ack_valid;
         if (ack_valid) begin
            vec_out <= win_found ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) : VEC_W'(SPUR_VEC);
         end
      end
   end

   // R5
   ipl_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ipl_o != '0) |-> $past(|pend));

   // R9
   vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && vec_out != VEC_W'(SPUR_VEC)) |->
         (vec_out > VEC_W'(VEC_BASE) && vec_out < VEC_W'(VEC_BASE + NUM_SRC)));
endmodule

// File: tb/test_lvl_irq_ctrl.sv
module test_lvl_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  ext_req = '0;
   logic [55:0] int_req = '0;
   logic        reg_we = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ack_valid = 1'b0;
   logic [2:0]  ack_level = '0;
   logic [2:0]  ipl_o;
   logic        vec_valid;
   logic [7:0]  vec_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lvl_irq_ctrl i_lvl_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ack_valid(ack_valid), .ack_level(ack_level), .ipl_o(ipl_o),
      .vec_valid(vec_valid), .vec_out(vec_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 7'(a);
      #1 d = reg_rdata;
   endtask

   task automatic set_ctl(input int src, input int lvl, input int pri);
      wr(src, 32'((lvl << 4) | pri));
   endtask

   task automatic ack(input int lvl, input string req, input int exp_vec);
      @(negedge clk);
      ack_valid = 1'b1; ack_level = 3'(lvl);
      @(negedge clk);
      ack_valid = 1'b0;
      chk(req, {31'd0, vec_valid}, 32'd1);
      chk(req, {24'd0, vec_out}, 32'(exp_vec));
   endtask

   task automatic settle();
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic clear_reqs();
      @(negedge clk);
      ext_req = '0; int_req = '0;
      settle();
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 ipl", {29'd0, ipl_o}, 32'd0);
      rd(64, d); chk("R1 mask lo", d, 32'hFFFF_FFFF);
      rd(65, d); chk("R1 mask hi", d, 32'hFFFF_FFFF);
      rd(20, d); chk("R1 ctl", d, 32'd0);
      // masked at reset: an active request is not pending
      int_req[12] = 1'b1;
      settle();
      chk("R1 masked ipl", {29'd0, ipl_o}, 32'd0);
      clear_reqs();
      wr(64, 32'd0);
      wr(65, 32'd0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      set_ctl(20, 5, 6);
      rd(20, d); chk("R2 ctl readback", d, 32'h56);
      wr(20, 32'hFFFF_FF8B);
      rd(20, d); chk("R2 ctl unused bits", d, 32'h03);
      wr(3, 32'h77);
      rd(3, d); chk("R2 fixed addr", d, 32'd0);
   endtask

   task automatic t_level0();
      logic [31:0] d;
      set_ctl(30, 0, 7);
      int_req[30-8] = 1'b1;
      settle();
      chk("R3 ipl", {29'd0, ipl_o}, 32'd0);
      rd(66, d); chk("R3 pending", d, 32'd0);
      ack(0, "R3 R9 ack level0", 24);
      clear_reqs();
   endtask

   task automatic t_mask();
      logic [31:0] d;
      set_ctl(40, 3, 1);
      int_req[40-8] = 1'b1;
      settle();
      rd(67, d); chk("R4 pending hi", d, 32'h100);
      chk("R4 ipl unmasked", {29'd0, ipl_o}, 32'd3);
      wr(65, 32'h100);
      @(negedge clk);
      chk("R4 ipl masked", {29'd0, ipl_o}, 32'd0);
      rd(67, d); chk("R4 pending masked", d, 32'd0);
      ack(3, "R4 ack masked", 24);
      wr(67, 32'hFFFF_FFFF);
      rd(65, d); chk("R4 pending write ignored", d, 32'h100);
      wr(65, 32'd0);
      clear_reqs();
   endtask

   task automatic t_levels();
      set_ctl(10, 2, 7);
      set_ctl(50, 6, 0);
      @(negedge clk);
      int_req[10-8] = 1'b1; int_req[50-8] = 1'b1;
      @(negedge clk);
      chk("R5 ipl after one edge", {29'd0, ipl_o}, 32'd6);
      ack(6, "R10 level beats priority", 64 + 50);
      ack(2, "R6 lower level ack", 64 + 10);
      @(negedge clk);
      int_req[50-8] = 1'b0;
      @(negedge clk);
      chk("R5 ipl drops", {29'd0, ipl_o}, 32'd2);
      clear_reqs();
   endtask

   task automatic t_prio();
      set_ctl(12, 4, 2);
      set_ctl(15, 4, 5);
      set_ctl(13, 4, 5);
      int_req[12-8] = 1'b1; int_req[13-8] = 1'b1; int_req[15-8] = 1'b1;
      settle();
      ack(4, "R7 tie lower number", 64 + 13);
      int_req[13-8] = 1'b0;
      ack(4, "R7 higher priority", 64 + 15);
      int_req[15-8] = 1'b0;
      ack(4, "R7 last left", 64 + 12);
      clear_reqs();
   endtask

   task automatic t_ext();
      set_ctl(20, 5, 3);
      ext_req[4] = 1'b1;
      settle();
      chk("R8 ext ipl", {29'd0, ipl_o}, 32'd5);
      int_req[20-8] = 1'b1;
      ack(5, "R8 ext over pri3", 69);
      set_ctl(20, 5, 4);
      ack(5, "R8 pri4 over ext", 84);
      clear_reqs();
      ext_req[6] = 1'b1;
      settle();
      chk("R8 ext line7 ipl", {29'd0, ipl_o}, 32'd7);
      ack(7, "R8 ext line7 vector", 71);
      clear_reqs();
   endtask

   task automatic t_spur();
      set_ctl(25, 1, 0);
      int_req[25-8] = 1'b1;
      settle();
      ack(3, "R9 empty level", 24);
      ack(1, "R6 level1 vector", 64 + 25);
      clear_reqs();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_level0();
      t_mask();
      t_levels();
      t_prio();
      t_ext();
      t_spur();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule